// File: doc/BRIEF.md
# Dual-Resolution SAR Conversion Sequencer

This block is the digital control for a successive-approximation analog-to-digital converter whose resolution is chosen at run time: 10 bits or 8 bits. A one-clock start pulse begins a conversion. The block latches the requested input channel and drives the analog multiplexer select. It then walks the bit trials most significant bit first. For each trial it puts a code on the DAC, waits for the DAC to settle, and keeps or clears the bit according to a single comparator input.

At the end of the last trial the code is latched into a result register. That register is shown on the output bus only while the read strobe is high. If the strobe is raised while a conversion is running, the bus carries the channel number that was latched, so the host can confirm its selection. A status flag is low while a conversion runs and high otherwise. A standby input forces the flag high at once, aborts any conversion in progress, and blocks new starts until standby has been low for one full clock. The latched channel and the last result survive standby.

The analog multiplexer, the DAC, the comparator and power gating lie outside this block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, statusFlag is 1, muxSel is 0, dacCode is 0, and the result register is 0, so dataOut reads 0 when readEn is 1.
- R2: A start is accepted only when three conditions hold at a rising edge: the block is idle, startPulse is 1, and standby is 0 at that edge and was also 0 at the previous edge. When a start is accepted, statusFlag is 0 from the following cycle until the conversion ends.
- R3: chanSel is captured at the first rising edge after the accepted start edge. From then on it drives muxSel, with binary encoding (3'b000 selects input 0, 3'b111 selects input 7). Later changes to chanSel have no effect.
- R4: With mode8 at 0 on the start edge, the block runs 10 trials from dacCode bit 9 down to bit 0. Each trial sets its bit and waits 4 clocks. The comparator is then sampled: 1 keeps the bit, 0 clears it. statusFlag returns to 1 exactly 41 rising edges after the start edge.
- R5: With mode8 at 1 on the start edge, the block runs 8 trials on dacCode bits 9 down to 2. Bits 1:0 of the result are 0. statusFlag returns to 1 exactly 33 edges after the start edge. A change of mode8 during a conversion has no effect.
- R6: While standby is 1, statusFlag is 1 in the same cycle. A conversion under way is abandoned at the next edge.
- R7: Standby leaves the latched channel (muxSel) and the result register unchanged. An aborted conversion does not update the result.
- R8: A start pulse is ignored, with no change to muxSel, statusFlag or the result, in three cases: it arrives during a conversion, it arrives during standby, or it arrives at the first edge after standby falls.
- R9: dataOe equals readEn. dataOut is all zeros whenever readEn is 0.
- R10: While readEn is 1, dataOut shows the result register when no conversion is running. During a conversion it shows {7'b0, latched channel}. The result register changes only at the edge that ends a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | One-cycle conversion start request |
| chanSel | input | 3 | Requested analog channel |
| mode8 | input | 1 | 1 selects 8-bit conversion, 0 selects 10-bit |
| standby | input | 1 | Power-down request; aborts and blocks conversions |
| readEn | input | 1 | Read strobe enabling the output bus |
| cmpIn | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dacCode | output | 10 | Trial code for the DAC |
| muxSel | output | 3 | Latched channel driving the analog multiplexer |
| dataOut | output | 10 | Result or channel readback; zero when not enabled |
| dataOe | output | 1 | Output-bus drive enable for the tri-state pads |
| statusFlag | output | 1 | 0 while converting, 1 when idle or in standby |

## Verification
The bench targets the edges where a sequencer typically slips:
- **Conversion length.** It checks the exact cycle at which the flag returns high in each resolution. An off-by-one settle counter would move that edge, and a design that ignored the latched mode would run the wrong number of trials.
- **Abort and restart.** It aborts a conversion with standby and then fires a start on the cycle standby falls. A design that let the aborted run write the result would change the held value, and one without the standby history would start a conversion that should have been refused.
- **Latching.** It changes chanSel and mode8 right after the capture edge and fires a second start mid-conversion. A design that did not latch would read the wrong channel or restart.
- **Extreme codes.** Input codes of all zeros and all ones exercise the first and last trials.

// File: rtl/sar_pkg.sv
package sar_pkg;
  parameter int SAR_MAX_W = 10;
  localparam int IDX_W = $clog2(SAR_MAX_W);

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_TRIAL} seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic             capture;  // latch channel, load MSB trial code
    logic             resolve;  // sample comparator for current bit
    logic             last;     // current bit is the final trial
    logic             busy;     // conversion in progress
    logic [IDX_W-1:0] bitIdx;   // bit under trial
  } seqStrobe_t;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int DATA_W      = SAR_MAX_W,
  parameter int NARROW_W    = 8,
  parameter int SETTLE_CLKS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       mode8,
  input  logic       standby,
  output seqStrobe_t strb
);
  localparam int SET_W = $clog2(SETTLE_CLKS + 1);
  localparam logic [SET_W-1:0] SETTLE_END = SET_W'(SETTLE_CLKS - 1);
  localparam logic [IDX_W-1:0] MSB_IDX    = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] NARROW_LOW = IDX_W'(DATA_W - NARROW_W);

  seqState_t        state;
  logic [SET_W-1:0] settleCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             mode8Q;
  logic             standbyQ;
  logic [IDX_W-1:0] lowIdx;
  logic             settled;

  assign lowIdx  = mode8Q ? NARROW_LOW : '0;
  assign settled = (settleCnt == SETTLE_END);

  always_comb begin
    strb.busy    = (state != ST_IDLE);
    strb.capture = (state == ST_ARM) && !standby;
    strb.resolve = (state == ST_TRIAL) && settled && !standby;
    strb.last    = (bitIdx == lowIdx);
    strb.bitIdx  = bitIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
      bitIdx    <= '0;
      mode8Q    <= 1'b0;
      standbyQ  <= 1'b1;
    end else begin
      standbyQ <= standby;
      case (state)
        ST_IDLE: begin
          if (startPulse && !standby && !standbyQ) begin
            state  <= ST_ARM;
            mode8Q <= mode8;
          end
        end
        ST_ARM: begin
          if (standby) begin
            state <= ST_IDLE;
          end else begin
            state     <= ST_TRIAL;
            bitIdx    <= MSB_IDX;
            settleCnt <= '0;
          end
        end
        ST_TRIAL: begin
          if (standby) begin
            state <= ST_IDLE;
          end else if (settled) begin
            settleCnt <= '0;
            if (strb.last) state <= ST_IDLE;
            else           bitIdx <= bitIdx - 1'b1;
          end else begin
            settleCnt <= settleCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_dp.sv
module sar_dp
  import sar_pkg::*;
#(
  parameter int DATA_W = SAR_MAX_W,
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [CHAN_W-1:0] chanSel,
  input  logic              cmpIn,
  input  logic              readEn,
  output logic [DATA_W-1:0] dacCode,
  output logic [CHAN_W-1:0] muxSel,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  localparam logic [DATA_W-1:0] MSB_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [CHAN_W-1:0] chanQ;
  logic [DATA_W-1:0] codeQ;
  logic [DATA_W-1:0] resultQ;
  logic [DATA_W-1:0] nextCode;

  always_comb begin
    nextCode = codeQ;
    nextCode[strb.bitIdx] = cmpIn;
    if (!strb.last && (strb.bitIdx != '0))
      nextCode[strb.bitIdx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanQ   <= '0;
      codeQ   <= '0;
      resultQ <= '0;
    end else begin
      if (strb.capture) begin
        chanQ <= chanSel;
        codeQ <= MSB_CODE;
      end else if (strb.resolve) begin
        codeQ <= nextCode;
        if (strb.last) resultQ <= nextCode;
      end
    end
  end

  assign dacCode = codeQ;
  assign muxSel  = chanQ;
  assign dataOe  = readEn;

  always_comb begin
    if (!readEn)        dataOut = '0;
    else if (strb.busy) dataOut = DATA_W'(chanQ);
    else                dataOut = resultQ;
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int DATA_W      = SAR_MAX_W,
  parameter int NARROW_W    = 8,
  parameter int CHAN_W      = 3,
  parameter int SETTLE_CLKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [CHAN_W-1:0] chanSel,
  input  logic              mode8,
  input  logic              standby,
  input  logic              readEn,
  input  logic              cmpIn,
  output logic [DATA_W-1:0] dacCode,
  output logic [CHAN_W-1:0] muxSel,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              statusFlag
);
  seqStrobe_t strb;

  sar_seq #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W), .SETTLE_CLKS(SETTLE_CLKS)
  ) u_seq (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .mode8(mode8),
    .standby(standby), .strb(strb)
  );

  sar_dp #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .chanSel(chanSel), .cmpIn(cmpIn),
    .readEn(readEn), .dacCode(dacCode), .muxSel(muxSel),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  assign statusFlag = !strb.busy || standby;
endmodule

// File: rtl/sar_conv_checker.sv
module sar_conv_checker #(
  parameter int DATA_W = 10,
  parameter int CHAN_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              standby,
  input logic              readEn,
  input logic [CHAN_W-1:0] muxSel,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input logic              statusFlag
);
  assert_stby_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> statusFlag);

  assert_stby_keeps_chan_R7: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> $stable(muxSel));

  assert_start_drops_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && statusFlag && !standby && $past(!standby) && $past(rstN))
      |=> (!statusFlag || standby));

  assert_busy_readback_R10: assert property (@(posedge clk) disable iff (!rstN)
    (readEn && !statusFlag) |-> (dataOut[DATA_W-1:CHAN_W] == '0));

  assert_bus_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !readEn |-> (!dataOe && dataOut == '0));
endmodule

bind sar_conv_ctrl sar_conv_checker #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .standby(standby),
  .readEn(readEn), .muxSel(muxSel), .dataOut(dataOut), .dataOe(dataOe),
  .statusFlag(statusFlag)
);

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic [2:0] chanSel = 3'd0;
  logic       mode8 = 1'b0;
  logic       standby = 1'b0;
  logic       readEn = 1'b0;
  logic       cmpIn;
  logic [9:0] dacCode;
  logic [2:0] muxSel;
  logic [9:0] dataOut;
  logic       dataOe;
  logic       statusFlag;

  int vectors = 0;
  int errors  = 0;
  bit checking = 1'b0;

  logic [9:0] ain [8];

  // analog model: comparator high when selected input is at or above DAC level
  assign cmpIn = (ain[muxSel] >= dacCode);

  sar_conv_ctrl i_sar_conv_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .chanSel(chanSel),
    .mode8(mode8), .standby(standby), .readEn(readEn), .cmpIn(cmpIn),
    .dacCode(dacCode), .muxSel(muxSel), .dataOut(dataOut), .dataOe(dataOe),
    .statusFlag(statusFlag)
  );

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 waiting for capture, 2 trials
  int         mPhase;
  int         mEdges;
  bit         mNarrow;
  bit         mPrevStby;
  logic [2:0] mChan;
  logic [9:0] mRes;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mEdges = 0; mNarrow = 0; mPrevStby = 1; mChan = 0; mRes = 0;
    end else begin
      if (mPhase == 0) begin
        if (startPulse && !standby && !mPrevStby) begin  // R2, R8
          mPhase = 1; mNarrow = mode8;
        end
      end else if (standby) begin
        mPhase = 0;                                       // R6 abort, R7 no update
      end else if (mPhase == 1) begin
        mChan = chanSel; mPhase = 2; mEdges = 0;          // R3
      end else begin
        mEdges++;
        if (mEdges == 4 * (mNarrow ? 8 : 10)) begin       // R4, R5 length
          mPhase = 0;
          mRes = mNarrow ? (ain[mChan] & 10'h3FC) : ain[mChan];
        end
      end
      mPrevStby = standby;
    end
  end

  always @(negedge clk) begin
    #5;
    if (checking) begin
      chk("R2/R6 statusFlag", {9'd0, statusFlag}, {9'd0, (mPhase == 0) || standby});
      chk("R3/R7 muxSel", {7'd0, muxSel}, {7'd0, mChan});
      chk("R9 dataOe", {9'd0, dataOe}, {9'd0, readEn});
      chk("R10 dataOut", dataOut,
          !readEn ? 10'd0 : (mPhase != 0) ? {7'd0, mChan} : mRes);
    end
  end

  task automatic convert(input logic [2:0] ch, input bit narrow, input string tag);
    @(negedge clk); startPulse = 1'b1; mode8 = narrow; chanSel = ch;
    @(negedge clk); startPulse = 1'b0;
    @(negedge clk); chanSel = ~ch; mode8 = ~narrow; readEn = 1'b1;
    repeat (3) @(negedge clk);
    readEn = 1'b0;
    repeat (42) @(negedge clk);
    readEn = 1'b1;
    #5 chk(tag, dataOut, narrow ? (ain[ch] & 10'h3FC) : ain[ch]);
    @(negedge clk); readEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    readEn = 1'b1;
    #5;
    rstN = 1'b1;
    // R1 reset state
    chk("R1 statusFlag", {9'd0, statusFlag}, 10'd1);
    chk("R1 muxSel", {7'd0, muxSel}, 10'd0);
    chk("R1 dacCode", dacCode, 10'd0);
    chk("R1 dataOut", dataOut, 10'd0);
    for (int i = 0; i < 8; i++) ain[i] = 10'((i * 181 + 37) % 1024);
    ain[1] = 10'h3FF; ain[2] = 10'h000; ain[3] = 10'h2A5; ain[7] = 10'h155;
    @(negedge clk); readEn = 1'b0; checking = 1'b1;

    convert(3'd3, 1'b0, "R4 10-bit result");
    convert(3'd1, 1'b1, "R5 8-bit result all ones");
    convert(3'd2, 1'b0, "R4 10-bit result zero");
    convert(3'd7, 1'b1, "R5 8-bit result");
    convert(3'd4, 1'b0, "R4 10-bit result");
    convert(3'd5, 1'b1, "R5 8-bit result");
    convert(3'd1, 1'b0, "R4 10-bit result all ones");

    // R8: second start while busy is ignored
    @(negedge clk); startPulse = 1'b1; mode8 = 1'b0; chanSel = 3'd6;
    @(negedge clk); startPulse = 1'b0;
    repeat (10) @(negedge clk);
    startPulse = 1'b1; chanSel = 3'd0; mode8 = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    repeat (35) @(negedge clk);
    readEn = 1'b1;
    #5 chk("R8 busy start ignored", dataOut, ain[6]);
    @(negedge clk); readEn = 1'b0;

    // R6/R7: standby aborts, keeps channel and result
    @(negedge clk); startPulse = 1'b1; mode8 = 1'b0; chanSel = 3'd7;
    @(negedge clk); startPulse = 1'b0;
    repeat (12) @(negedge clk);
    standby = 1'b1; chanSel = 3'd5;
    #5 chk("R6 flag high at once", {9'd0, statusFlag}, 10'd1);
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0; readEn = 1'b1;
    #5 chk("R7 result kept", dataOut, ain[6]);
    chk("R7 channel kept", {7'd0, muxSel}, 10'd7);
    repeat (3) @(negedge clk);
    // R8: start on the edge standby falls is ignored
    standby = 1'b0; startPulse = 1'b1; readEn = 1'b0;
    @(negedge clk); startPulse = 1'b0;
    #5 chk("R8 start after standby ignored", {9'd0, statusFlag}, 10'd1);
    repeat (2) @(negedge clk);
    convert(3'd0, 1'b0, "R4 10-bit after standby");
    convert(3'd7, 1'b0, "R10 result readback");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule